// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the virtual byte address of a memory-format load or store and screens it for natural alignment before it reaches the memory stage. Each instruction word carries a six-bit opcode, a data register number, a base register number and a signed 16-bit offset. The unit adds the sign-extended offset to the 64-bit base value. It takes the access width (four-byte or eight-byte) and the direction from the opcode.

An access that is not naturally aligned for its width is never split. It is passed on flagged as an alignment fault, with the raw computed address for trap reporting, and the memory stage must not act on it. An optional big-endian mode swaps the four-byte lane within an eight-byte word by inverting address bit 2 on four-byte accesses. The outputs sit in a single register stage with a valid/ready handshake, so a stalled memory stage holds the result in place.

Top module: `eff_addr_unit`

## Requirements
- R1: On an accepted memory opcode, `effAddr` equals the base value plus the instruction's bits 15:0 sign-extended to 64 bits, with modulo 2^64 wraparound. It appears together with `outValid` one clock after the cycle in which `inValid` and `inReady` are both high.
- R2: When the base register number (instruction bits 20:16) is 31, the base is taken as zero and `baseVal` has no effect on `effAddr`.
- R3: `dataReg` reports instruction bits 25:21. Opcode (bits 31:26) 0x28 is a four-byte load, 0x29 an eight-byte load, 0x2C a four-byte store and 0x2D an eight-byte store. `isStore` mirrors opcode bit 2 and `isQuad` mirrors opcode bit 0.
- R4: `alignFault` is high exactly when a four-byte access has address bits 1:0 not both zero, or when an eight-byte access has address bits 2:0 not all zero.
- R5: With `bigEndian` high, an aligned four-byte access presents its address with bit 2 inverted. Eight-byte accesses are never altered.
- R6: A faulting access reports the unaltered computed address, even in big-endian mode.
- R7: While `outValid` is high and `outReady` is low, every output holds its value and `inReady` is low, so no new instruction is taken.
- R8: An instruction whose opcode is not one of the four memory opcodes is consumed and produces no output (`outValid` stays low).
- R9: After reset, `outValid` and `alignFault` are low, `effAddr` is zero and `inReady` is high.
- R10: With `outReady` held high, one instruction per clock is accepted, and the outputs follow the input order with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and base value are present |
| inReady | output | 1 | Unit can take an instruction this cycle |
| instrWord | input | 32 | Memory-format instruction word |
| baseVal | input | 64 | Value of the base register |
| bigEndian | input | 1 | Selects big-endian lane numbering |
| outValid | output | 1 | Result register holds an entry |
| outReady | input | 1 | Memory stage takes the entry this cycle |
| effAddr | output | 64 | Presented address, or raw address on a fault |
| dataReg | output | 5 | Data register number |
| isStore | output | 1 | Entry is a store |
| isQuad | output | 1 | Entry is an eight-byte access |
| alignFault | output | 1 | Entry is misaligned; no memory request |

## Verification
The lane swap and the alignment check both act on the same sum in the same cycle. A four-byte access in big-endian mode at an address ending in 2 or 6 makes both apply at once. The bench drives such accesses and expects the fault flag to be raised with the address left unaltered. It also drives aligned big-endian four-byte accesses at both halves of an eight-byte word, where bit 2 must flip, and misaligned ones, where the fault must take priority over the swap.

// File: rtl/eau_pkg.sv
package eau_pkg;

  // Control strobes handed from the control module to the datapath.
  typedef struct packed {
    logic capture;   // load the result register this cycle
    logic zeroBase;  // base register is the hardwired zero register
    logic swapLane;  // invert bit 2 for a big-endian four-byte access
    logic isStore;   // direction of the access
    logic isQuad;    // eight-byte access width
  } eauStrobe_t;

  // Upper three opcode bits shared by every memory-format access.
  localparam logic [2:0] MEM_OPC_TAG = 3'b101;

endpackage

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [OPC_W-1:0] opcode,
  input  logic [REG_W-1:0] rbNum,
  input  logic             bigEndian,
  input  logic             outReady,
  output logic             outValid,
  output eauStrobe_t       strobe
);

  localparam logic [REG_W-1:0] ZERO_REG = '1;

  logic memOp;
  logic accept;

  // Memory opcodes: tag in the top three bits, bit 1 clear.
  assign memOp   = (opcode[OPC_W-1 -: 3] == MEM_OPC_TAG) && !opcode[1];
  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else if (inReady) begin
      outValid <= accept && memOp;
    end
  end

  always_comb begin
    strobe.capture  = accept && memOp;
    strobe.zeroBase = (rbNum == ZERO_REG);
    strobe.swapLane = bigEndian && !opcode[0];
    strobe.isStore  = opcode[2];
    strobe.isQuad   = opcode[0];
  end

endmodule

// File: rtl/eau_datapath.sv
module eau_datapath
  import eau_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int DISP_W        = 16,
  parameter int REG_W         = 5,
  parameter bit LANE_SWAP_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  eauStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [REG_W-1:0]  raNum,
  output logic [ADDR_W-1:0] effAddr,
  output logic [REG_W-1:0]  dataReg,
  output logic              isStore,
  output logic              isQuad,
  output logic              alignFault
);

  localparam int EXT_W   = ADDR_W - DISP_W;
  localparam int LANE_BIT = 2;

  logic [ADDR_W-1:0] baseSel;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] rawSum;
  logic [ADDR_W-1:0] presented;
  logic              misaligned;

  assign baseSel = strobe.zeroBase ? '0 : baseVal;
  assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign rawSum  = baseSel + dispExt;

  // Natural alignment: two low bits for four bytes, three for eight.
  assign misaligned = strobe.isQuad ? (rawSum[2:0] != 3'b000)
                                    : (rawSum[1:0] != 2'b00);

  generate
    if (LANE_SWAP_EN) begin : gLaneSwap
      logic [ADDR_W-1:0] laneMask;
      assign laneMask  = ADDR_W'(1) << LANE_BIT;
      // A fault reports the raw address, so the swap is suppressed.
      assign presented = (strobe.swapLane && !misaligned) ? (rawSum ^ laneMask)
                                                          : rawSum;
    end else begin : gNoSwap
      logic unusedSwap;
      assign unusedSwap = strobe.swapLane;
      assign presented  = rawSum;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr    <= '0;
      dataReg    <= '0;
      isStore    <= 1'b0;
      isQuad     <= 1'b0;
      alignFault <= 1'b0;
    end else if (strobe.capture) begin
      effAddr    <= presented;
      dataReg    <= raNum;
      isStore    <= strobe.isStore;
      isQuad     <= strobe.isQuad;
      alignFault <= misaligned;
    end
  end

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int INSTR_W      = 32,
  parameter int DISP_W       = 16,
  parameter int REG_W        = 5,
  parameter bit LANE_SWAP_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic               bigEndian,
  output logic               outValid,
  input  logic               outReady,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [REG_W-1:0]   dataReg,
  output logic               isStore,
  output logic               isQuad,
  output logic               alignFault
);

  localparam int RB_LO  = DISP_W;
  localparam int RA_LO  = DISP_W + REG_W;
  localparam int OPC_LO = DISP_W + 2 * REG_W;
  localparam int OPC_W  = INSTR_W - OPC_LO;

  logic [OPC_W-1:0]  opcode;
  logic [REG_W-1:0]  raNum;
  logic [REG_W-1:0]  rbNum;
  logic [DISP_W-1:0] disp;
  eauStrobe_t        strobe;

  assign opcode = instrWord[INSTR_W-1:OPC_LO];
  assign raNum  = instrWord[RA_LO +: REG_W];
  assign rbNum  = instrWord[RB_LO +: REG_W];
  assign disp   = instrWord[DISP_W-1:0];

  eau_ctrl #(
    .OPC_W (OPC_W),
    .REG_W (REG_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inReady   (inReady),
    .opcode    (opcode),
    .rbNum     (rbNum),
    .bigEndian (bigEndian),
    .outReady  (outReady),
    .outValid  (outValid),
    .strobe    (strobe)
  );

  eau_datapath #(
    .ADDR_W       (ADDR_W),
    .DISP_W       (DISP_W),
    .REG_W        (REG_W),
    .LANE_SWAP_EN (LANE_SWAP_EN)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseVal    (baseVal),
    .disp       (disp),
    .raNum      (raNum),
    .effAddr    (effAddr),
    .dataReg    (dataReg),
    .isStore    (isStore),
    .isQuad     (isQuad),
    .alignFault (alignFault)
  );

endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
  parameter int ADDR_W  = 64,
  parameter int INSTR_W = 32,
  parameter int DISP_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic [INSTR_W-1:0] instrWord,
  input logic [ADDR_W-1:0]  baseVal,
  input logic               bigEndian,
  input logic               outValid,
  input logic               outReady,
  input logic [ADDR_W-1:0]  effAddr,
  input logic               isQuad,
  input logic               alignFault
);

  logic takeIn;
  logic memWord;
  logic plainBase;
  logic [ADDR_W-1:0] expectSum;

  assign takeIn    = inValid && inReady;
  assign memWord   = (instrWord[INSTR_W-1 -: 3] == 3'b101) && !instrWord[INSTR_W-5];
  assign plainBase = (instrWord[DISP_W+4:DISP_W] != 5'd31);
  assign expectSum = baseVal + {{(ADDR_W-DISP_W){instrWord[DISP_W-1]}}, instrWord[DISP_W-1:0]};

  // R1: little-endian sum appears one cycle after acceptance
  assert_sum_R1: assert property (@(posedge clk) disable iff (!rstN)
    (takeIn && memWord && plainBase && !bigEndian) |=> (outValid && effAddr == $past(expectSum)));

  // R4: an unflagged entry is naturally aligned
  assert_aligned_quad_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !alignFault && isQuad) |-> (effAddr[2:0] == 3'b000));
  assert_aligned_long_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !alignFault && !isQuad) |-> (effAddr[1:0] == 2'b00));

  // R7: a stalled entry holds and blocks new input
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(effAddr) && $stable(alignFault) && $stable(isQuad)));
  assert_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R8: non-memory words leave no entry
  assert_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (takeIn && !memWord) |=> !outValid);

  // R9: first cycle out of reset is empty
  assert_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && inReady));

endmodule

bind eff_addr_unit eau_checker #(
  .ADDR_W  (ADDR_W),
  .INSTR_W (INSTR_W),
  .DISP_W  (DISP_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .instrWord  (instrWord),
  .baseVal    (baseVal),
  .bigEndian  (bigEndian),
  .outValid   (outValid),
  .outReady   (outReady),
  .effAddr    (effAddr),
  .isQuad     (isQuad),
  .alignFault (alignFault)
);

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] instrWord = '0;
  logic [63:0] baseVal = '0;
  logic        bigEndian = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] effAddr;
  logic [4:0]  dataReg;
  logic        isStore;
  logic        isQuad;
  logic        alignFault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [5:0] OP_LDL = 6'h28;
  localparam logic [5:0] OP_LDQ = 6'h29;
  localparam logic [5:0] OP_STL = 6'h2C;
  localparam logic [5:0] OP_STQ = 6'h2D;
  localparam logic [5:0] OP_OTH = 6'h2A;

  always #2 clk = ~clk;

  eff_addr_unit dut_i (
    .clk (clk), .rstN (rstN), .inValid (inValid), .inReady (inReady),
    .instrWord (instrWord), .baseVal (baseVal), .bigEndian (bigEndian),
    .outValid (outValid), .outReady (outReady), .effAddr (effAddr),
    .dataReg (dataReg), .isStore (isStore), .isQuad (isQuad),
    .alignFault (alignFault)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] ra, logic [4:0] rb, logic [15:0] d);
    return {op, ra, rb, d};
  endfunction

  function automatic logic [63:0] rawAddr(logic [4:0] rb, logic [63:0] b, logic [15:0] d);
    logic [63:0] base = (rb == 5'd31) ? 64'd0 : b;
    return base + {{48{d[15]}}, d};
  endfunction

  function automatic logic badAlign(logic [63:0] a, logic quad);
    return quad ? (a[2:0] != 0) : (a[1:0] != 0);
  endfunction

  function automatic logic [63:0] shownAddr(logic [63:0] a, logic quad, logic be);
    if (be && !quad && !badAlign(a, quad)) return a ^ 64'h4;
    return a;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Let any pending entry leave.
  task automatic drain();
    @(negedge clk);
    inValid  = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
  endtask

  // Send one instruction and compare the whole result.
  task automatic sendCheck(string req, logic [5:0] op, logic [4:0] ra, logic [4:0] rb,
                           logic [15:0] d, logic [63:0] b, logic be);
    logic [63:0] raw;
    logic quad;
    drain();
    instrWord = mk(op, ra, rb, d);
    baseVal   = b;
    bigEndian = be;
    inValid   = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    quad = op[0];
    raw  = rawAddr(rb, b, d);
    chk({req, " valid"}, 64'(outValid), 64'd1);
    chk({req, " addr"}, effAddr, shownAddr(raw, quad, be));
    chk({req, " fault"}, 64'(alignFault), 64'(badAlign(raw, quad)));
    chk({req, " ra"}, 64'(dataReg), 64'(ra));
    chk({req, " store"}, 64'(isStore), 64'(op[2]));
    chk({req, " quad"}, 64'(isQuad), 64'(quad));
  endtask

  task automatic testReset();
    chk("R9 outValid", 64'(outValid), 64'd0);
    chk("R9 inReady", 64'(inReady), 64'd1);
    chk("R9 effAddr", effAddr, 64'd0);
    chk("R9 fault", 64'(alignFault), 64'd0);
  endtask

  task automatic testSum();
    sendCheck("R1 pos", OP_LDQ, 5'd3, 5'd4, 16'h0010, 64'h1000, 1'b0);
    sendCheck("R1 neg", OP_LDQ, 5'd3, 5'd4, 16'hFFF8, 64'h1000, 1'b0);
    sendCheck("R1 wrap", OP_LDL, 5'd1, 5'd2, 16'h8000, 64'h0, 1'b0);
    sendCheck("R1 carry", OP_STQ, 5'd9, 5'd2, 16'h0008, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0);
  endtask

  task automatic testZeroBase();
    sendCheck("R2 zero", OP_LDL, 5'd5, 5'd31, 16'h0040, 64'hDEAD_0000, 1'b0);
    chk("R2 ignores base", effAddr, 64'h40);
  endtask

  task automatic testFields();
    sendCheck("R3 stl", OP_STL, 5'd7, 5'd1, 16'h0000, 64'h2000, 1'b0);
    sendCheck("R3 ldq", OP_LDQ, 5'd0, 5'd1, 16'h0000, 64'h2000, 1'b0);
    sendCheck("R3 r31", OP_STQ, 5'd31, 5'd1, 16'h0000, 64'h2000, 1'b0);
  endtask

  task automatic testAlign();
    sendCheck("R4 long2", OP_LDL, 5'd1, 5'd2, 16'h0000, 64'h1002, 1'b0);
    chk("R4 long2 flag", 64'(alignFault), 64'd1);
    sendCheck("R4 long4", OP_LDL, 5'd1, 5'd2, 16'h0000, 64'h1004, 1'b0);
    chk("R4 long4 flag", 64'(alignFault), 64'd0);
    sendCheck("R4 quad4", OP_LDQ, 5'd1, 5'd2, 16'h0000, 64'h1004, 1'b0);
    chk("R4 quad4 flag", 64'(alignFault), 64'd1);
    sendCheck("R4 quad1", OP_STQ, 5'd1, 5'd2, 16'h0001, 64'h1000, 1'b0);
  endtask

  task automatic testBigEndian();
    sendCheck("R5 lo", OP_LDL, 5'd1, 5'd2, 16'h0000, 64'h1000, 1'b1);
    chk("R5 lo addr", effAddr, 64'h1004);
    sendCheck("R5 hi", OP_STL, 5'd1, 5'd2, 16'h0004, 64'h1000, 1'b1);
    chk("R5 hi addr", effAddr, 64'h1000);
    sendCheck("R5 quad", OP_LDQ, 5'd1, 5'd2, 16'h0008, 64'h1000, 1'b1);
    chk("R5 quad addr", effAddr, 64'h1008);
  endtask

  task automatic testFaultSwap();
    sendCheck("R6 be6", OP_LDL, 5'd1, 5'd2, 16'h0006, 64'h1000, 1'b1);
    chk("R6 be6 raw", effAddr, 64'h1006);
    sendCheck("R6 be2", OP_STL, 5'd1, 5'd2, 16'h0002, 64'h1000, 1'b1);
    chk("R6 be2 raw", effAddr, 64'h1002);
    bigEndian = 1'b0;
  endtask

  task automatic testStall();
    drain();
    outReady  = 1'b0;
    instrWord = mk(OP_LDQ, 5'd2, 5'd3, 16'h0010);
    baseVal   = 64'h3000;
    inValid   = 1'b1;
    @(negedge clk);
    chk("R7 first out", effAddr, 64'h3010);
    instrWord = mk(OP_LDQ, 5'd4, 5'd3, 16'h0020);
    @(negedge clk);
    chk("R7 blocked", 64'(inReady), 64'd0);
    chk("R7 held addr", effAddr, 64'h3010);
    chk("R7 held ra", 64'(dataReg), 64'd2);
    chk("R7 held valid", 64'(outValid), 64'd1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R7 next addr", effAddr, 64'h3020);
    chk("R7 next ra", 64'(dataReg), 64'd4);
  endtask

  task automatic testNonMem();
    drain();
    instrWord = mk(OP_OTH, 5'd6, 5'd2, 16'h0000);
    baseVal   = 64'h5000;
    inValid   = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 no entry", 64'(outValid), 64'd0);
    chk("R8 addr kept", effAddr, 64'h3020);
  endtask

  task automatic testStream();
    drain();
    for (int i = 0; i < 4; i++) begin
      instrWord = mk(OP_LDL, 5'(i), 5'd1, 16'(i * 4));
      baseVal   = 64'h8000;
      inValid   = 1'b1;
      @(negedge clk);
      chk("R10 valid", 64'(outValid), 64'd1);
      chk("R10 addr", effAddr, 64'h8000 + 64'(i * 4));
      chk("R10 order", 64'(dataReg), 64'(i));
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSum();
    testZeroBase();
    testFields();
    testAlign();
    testBigEndian();
    testFaultSwap();
    testStall();
    testNonMem();
    testStream();
    drain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule